// File: doc/BRIEF.md
# Programmable Asynchronous Serial Channel

This block is a full-duplex asynchronous serial channel. A host writes a character into a one-deep transmit holding register. The transmitter frames it with a start bit, five to eight data bits sent least significant bit first, an optional parity bit and a stop period of programmable length, and shifts the frame out on `txd`. The receiver oversamples `rxd` sixteen times per bit. It rejects glitches that look like start bits, assembles characters into a one-deep receive holding register, and flags parity, framing and overrun errors. It also detects line breaks, including a break that begins in the middle of a character.

All bit timing comes from `tick16`, a one-cycle clock enable that pulses at sixteen times the bit rate. A two-bit channel mode selects how the transmitter, the receiver and the two serial pins are connected: normal, echo, local loopback or remote loopback. Four status conditions can raise the active-low interrupt output, and each has its own mask bit.

Top module: `serial_chan`

## Requirements
- R1: When idle, `txd` is high. A transmitted frame is one low start bit, then `5 + len_sel` data bits sent LSB first, then the parity bit when parity is enabled, then a high stop period. Each bit except the stop lasts 16 ticks.
- R2: `par_sel` selects the parity mode: 0 is none, 1 is even (data plus parity holds an even number of ones), 2 is odd, and 3 is fixed (the parity bit equals `par_fix`). The receiver checks the same rule.
- R3: The stop period lasts `stop_ticks` ticks, clamped to the range 9 to 32. With back-to-back characters, `txd` stays high for exactly that many ticks between the frames.
- R4: `tx_ready` is high while the transmit holding register is empty. A write clears it. It sets again when the character moves into the shifter, which happens on a tick.
- R5: A received character appears on `host_rdata`, masked to its length, with `rx_ready` set. A one-cycle `host_rd` pulse clears `rx_ready` and the error flags.
- R6: The receiver samples a low level on `rxd` again 8 ticks later. If the line is high by then, the low level is dropped as a false start and produces no character, error or break.
- R7: `par_err` and `frm_err` (stop bit sampled low) are stored with their character. If a character completes while `rx_ready` is still set, `overrun` sets and the unread character is kept.
- R8: A frame received as all zeros, including parity and stop, sets `brk_active` and `brk_change` and delivers no character. A break that starts mid-character first delivers the garbled character with `frm_err`. The break ends after `rxd` has been high for 16 consecutive ticks, which clears `brk_active` and sets `brk_change` again. `brk_clear` clears `brk_change`.
- R9: While `brk_send` is high in normal mode, `txd` is held low.
- R10: `chan_sel` selects the channel mode. In mode 0 (normal), the transmitter drives `txd` and `rxd` feeds the receiver. In mode 1 (echo), `rxd` is repeated on `txd` and also received. In mode 2 (local loopback), the transmitter feeds the receiver and `txd` stays high. In mode 3 (remote loopback), `rxd` is repeated on `txd` and received characters never set `rx_ready`.
- R11: `irq_n` is low exactly when any status bit is set whose mask bit in `irq_mask` is also set. The status bits are bit 0 `tx_ready`, bit 1 `rx_ready`, bit 2 `brk_change`, and bit 3 the OR of `par_err`, `frm_err` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| host_wr | input | 1 | Write strobe for the transmit holding register |
| host_wdata | input | 8 | Character to transmit |
| host_rd | input | 1 | Read strobe; acknowledges the received character |
| host_rdata | output | 8 | Received character |
| len_sel | input | 2 | Character length minus five |
| par_sel | input | 2 | Parity mode |
| par_fix | input | 1 | Parity level used in fixed parity mode |
| stop_ticks | input | 6 | Stop period length in ticks |
| chan_sel | input | 2 | Channel routing mode |
| brk_send | input | 1 | Hold the transmit line low |
| brk_clear | input | 1 | Clear the break-change status |
| irq_mask | input | 4 | Interrupt enable for each status source |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_ready | output | 1 | Received character available |
| par_err | output | 1 | Parity error on the held character |
| frm_err | output | 1 | Framing error on the held character |
| overrun | output | 1 | A character was lost while one was unread |
| brk_active | output | 1 | A line break is in progress |
| brk_change | output | 1 | Break started or ended since it was last cleared |
| irq_n | output | 1 | Active-low interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
Most internal faults show up as a wrong bit pattern on `txd` or a wrong character on `host_rdata` within one frame time, about 160 ticks. A tick counter that is off by one skews the sampling point or stretches the stop period. The stop period is measured edge to edge in clock cycles, so a one-tick error is caught. A receiver state machine that does not leave its break state leaves `brk_active` high and blocks the next character, so each break test is followed by a normal character to prove recovery. Routing faults show within one bit time as `txd` failing to follow `rxd` or failing to stay quiet in local loopback.

// File: rtl/sc_pkg.sv
// Shared types and helpers for the asynchronous serial channel.
// Assumes characters of five to eight bits held in an 8-bit container.
package sc_pkg;

    typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD, PAR_FIXED} par_mode_e;
    typedef enum logic [1:0] {CH_NORMAL, CH_ECHO, CH_LOCAL, CH_REMOTE} chan_mode_e;
    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK} rx_state_e;

    // Keep only the bits that belong to a character of length 5 + sel.
    function automatic logic [7:0] len_mask(input logic [1:0] sel);
        return 8'hFF >> (2'd3 - sel);
    endfunction

    // Parity bit that goes with a character under the given mode.
    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] sel,
                                     input par_mode_e m, input logic fix);
        logic x;
        x = ^(d & len_mask(sel));
        case (m)
            PAR_EVEN:  return x;
            PAR_ODD:   return ~x;
            PAR_FIXED: return fix;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sc_tx.sv
// Transmitter: one holding register feeding a frame shifter.
// Bit timing advances only on tick; each bit except the stop lasts OVS ticks.
// Assumes the format inputs are stable while a frame is being sent.
module sc_tx
    import sc_pkg::*;
#(
    parameter int OVS = 16,
    localparam int CW = $clog2(2 * OVS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    len_sel,
    input  logic [1:0]    par_sel,
    input  logic          par_fix,
    input  logic [CW-1:0] stop_len,
    input  logic          brk_cmd,
    output logic          tx_line,
    output logic          tx_ready
);
    localparam int MIN_STOP = OVS / 2 + 1;
    localparam int MAX_STOP = 2 * OVS;

    tx_state_e     st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] stop_eff;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic [7:0]    hold;
    logic          hold_full;
    logic          pbit;
    logic          take;
    logic          raw;

    // Clamp the requested stop length to the supported range.
    always_comb begin
        if (stop_len < CW'(MIN_STOP))      stop_eff = CW'(MIN_STOP);
        else if (stop_len > CW'(MAX_STOP)) stop_eff = CW'(MAX_STOP);
        else                               stop_eff = stop_len;
    end

    // Moment the holding register is handed to the shifter.
    assign take = tick && hold_full &&
                  ((st == TX_IDLE) || (st == TX_STOP && cnt == stop_eff - 1'b1));

    // Holding register; a write wins over a same-cycle hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold      <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // Frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (tick) begin
            if (take) begin
                st    <= TX_START;
                cnt   <= '0;
                shreg <= hold & len_mask(len_sel);
                pbit  <= par_bit(hold, len_sel, par_mode_e'(par_sel), par_fix);
            end else begin
                case (st)
                    TX_START: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt  <= '0;
                            bidx <= '0;
                            st   <= TX_DATA;
                        end else cnt <= cnt + 1'b1;
                    end
                    TX_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            if (bidx == {1'b0, len_sel} + 3'd4)
                                st <= (par_sel == PAR_NONE) ? TX_STOP : TX_PAR;
                            else bidx <= bidx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    TX_PAR: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            st  <= TX_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    TX_STOP: begin
                        if (cnt == stop_eff - 1'b1) begin
                            cnt <= '0;
                            st  <= TX_IDLE;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // Line level chosen by the current frame position.
    always_comb begin
        case (st)
            TX_START: raw = 1'b0;
            TX_DATA:  raw = shreg[bidx];
            TX_PAR:   raw = pbit;
            default:  raw = 1'b1;
        endcase
    end

    assign tx_line  = raw & ~brk_cmd;
    assign tx_ready = ~hold_full;

    // R4: a write always leaves the holding register occupied.
    p_wr_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_ready);
    // R4: the register only empties on a tick.
    p_ready_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tick));

endmodule

// File: rtl/sc_rx.sv
// Receiver: 16x oversampling frame engine with false-start rejection,
// error flags, break tracking and a one-deep holding register.
// Assumes rx_in is already synchronised to clk.
module sc_rx
    import sc_pkg::*;
#(
    parameter int OVS = 16,
    localparam int NW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] len_sel,
    input  logic [1:0] par_sel,
    input  logic       par_fix,
    input  logic       rd_en,
    input  logic       clr_brk,
    input  logic       no_deliver,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       par_err,
    output logic       frm_err,
    output logic       ovr,
    output logic       brk_active,
    output logic       brk_chg
);
    localparam logic [NW-1:0] HALF = NW'(OVS / 2 - 1);
    localparam logic [NW-1:0] LAST = NW'(OVS - 1);

    rx_state_e     st;
    logic [NW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    sh;
    logic          ones;
    logic          pbit;
    logic          stop_evt, brk_start, brk_end, done_ev, perr_now;

    assign stop_evt  = tick && st == RX_STOP && cnt == LAST;
    assign brk_start = stop_evt && !rx_in && !ones;
    assign done_ev   = stop_evt && !brk_start;
    assign brk_end   = tick && st == RX_BRK && rx_in && cnt == LAST;
    assign perr_now  = (par_sel != PAR_NONE) &&
                       (pbit != par_bit(sh, len_sel, par_mode_e'(par_sel), par_fix));

    // Frame engine stepping on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            ones <= 1'b0;
            pbit <= 1'b0;
        end else if (tick) begin
            case (st)
                RX_IDLE: if (!rx_in) begin
                    st  <= RX_START;
                    cnt <= '0;
                end
                RX_START: begin
                    if (cnt == HALF) begin
                        cnt  <= '0;
                        bidx <= '0;
                        sh   <= '0;
                        ones <= 1'b0;
                        st   <= rx_in ? RX_IDLE : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        sh[bidx] <= rx_in;
                        ones     <= ones | rx_in;
                        if (bidx == {1'b0, len_sel} + 3'd4)
                            st <= (par_sel == PAR_NONE) ? RX_STOP : RX_PAR;
                        else bidx <= bidx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                RX_PAR: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        pbit <= rx_in;
                        ones <= ones | rx_in;
                        st   <= RX_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RX_STOP: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= brk_start ? RX_BRK : RX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                RX_BRK: begin
                    if (!rx_in)          cnt <= '0;
                    else if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // Holding register and per-character flags; a completing character beats a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (rd_en) begin
                rx_ready <= 1'b0;
                par_err  <= 1'b0;
                frm_err  <= 1'b0;
                ovr      <= 1'b0;
            end
            if (done_ev && !no_deliver) begin
                if (rx_ready && !rd_en) ovr <= 1'b1;
                else begin
                    rx_data  <= sh;
                    rx_ready <= 1'b1;
                    par_err  <= perr_now;
                    frm_err  <= !rx_in;
                end
            end
        end
    end

    // Break state and its change event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_active <= 1'b0;
            brk_chg    <= 1'b0;
        end else begin
            if (brk_start) brk_active <= 1'b1;
            else if (brk_end) brk_active <= 1'b0;
            if (brk_start || brk_end) brk_chg <= 1'b1;
            else if (clr_brk)         brk_chg <= 1'b0;
        end
    end

    // R5: a read with no competing character empties the register.
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done_ev) |=> !rx_ready);
    // R7: an overrun keeps the unread character.
    p_overrun_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && !no_deliver && rx_ready && !rd_en) |=> (ovr && $stable(rx_data)));
    // R8: a break only ends while the line is high.
    p_break_ends_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_active) |-> $past(rx_in));
    // R10: remote loopback never raises receiver-ready.
    p_remote_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (no_deliver && !rx_ready) |=> !rx_ready);

endmodule

// File: rtl/serial_chan.sv
// Top of the asynchronous serial channel: input synchroniser, channel
// routing between transmitter, receiver and pins, and interrupt masking.
// Assumes tick16 is a single-cycle enable at 16x the bit rate.
module serial_chan
    import sc_pkg::*;
#(
    parameter int OVS = 16,
    localparam int SW = $clog2(2 * OVS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    input  logic [1:0]    len_sel,
    input  logic [1:0]    par_sel,
    input  logic          par_fix,
    input  logic [SW-1:0] stop_ticks,
    input  logic [1:0]    chan_sel,
    input  logic          brk_send,
    input  logic          brk_clear,
    input  logic [3:0]    irq_mask,
    output logic          tx_ready,
    output logic          rx_ready,
    output logic          par_err,
    output logic          frm_err,
    output logic          overrun,
    output logic          brk_active,
    output logic          brk_change,
    output logic          irq_n,
    output logic          txd,
    input  logic          rxd
);
    logic [1:0] rxd_sync;
    logic       tx_line;
    logic       rx_src;
    logic [3:0] irq_src;
    chan_mode_e mode;

    assign mode = chan_mode_e'(chan_sel);

    // Two-stage synchroniser for the asynchronous receive pin.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    sc_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .wr_en(host_wr), .wr_data(host_wdata),
        .len_sel(len_sel), .par_sel(par_sel), .par_fix(par_fix),
        .stop_len(stop_ticks), .brk_cmd(brk_send),
        .tx_line(tx_line), .tx_ready(tx_ready)
    );

    // Receiver input: the transmitter in local loopback, the pin otherwise.
    assign rx_src = (mode == CH_LOCAL) ? tx_line : rxd_sync[1];

    sc_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_in(rx_src),
        .len_sel(len_sel), .par_sel(par_sel), .par_fix(par_fix),
        .rd_en(host_rd), .clr_brk(brk_clear), .no_deliver(mode == CH_REMOTE),
        .rx_data(host_rdata), .rx_ready(rx_ready), .par_err(par_err),
        .frm_err(frm_err), .ovr(overrun), .brk_active(brk_active),
        .brk_chg(brk_change)
    );

    // Transmit pin source for each channel mode.
    always_comb begin
        case (mode)
            CH_NORMAL: txd = tx_line;
            CH_LOCAL:  txd = 1'b1;
            default:   txd = rxd_sync[1];
        endcase
    end

    // Interrupt: any enabled status source pulls the line low.
    assign irq_src = {par_err | frm_err | overrun, brk_change, rx_ready, tx_ready};
    assign irq_n   = ~|(irq_src & irq_mask);

    // R11: with every source masked the request stays inactive.
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 4'b0) |-> irq_n);
    // R9: a break command forces the line low in normal mode.
    p_brk_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_send && chan_sel == 2'd0) |-> !txd);
    // R10: local loopback keeps the pin idle.
    p_local_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel == 2'd2) |-> txd);

endmodule

// File: tb/tb_serial_chan.sv
`timescale 1ns/1ps
module tb_serial_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic [1:0] len_sel = 2'd3, par_sel = 2'd0, chan_sel = 2'd0;
    logic       par_fix = 1'b0, brk_send = 1'b0, brk_clear = 1'b0;
    logic [5:0] stop_ticks = 6'd16;
    logic [3:0] irq_mask = 4'b0;
    logic       tx_ready, rx_ready, par_err, frm_err, overrun;
    logic       brk_active, brk_change, irq_n, txd;
    logic       rxd = 1'b1;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    serial_chan dut (.*);

    always #10 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); brk_clear = 1'b1;
        @(negedge clk); brk_clear = 1'b0;
    endtask

    function automatic logic ref_par(input logic [7:0] d, input int len, input int pm, input logic fx);
        logic x;
        x = ^(d & 8'((1 << len) - 1));
        if (pm == 1) return x;
        if (pm == 2) return ~x;
        return fx;
    endfunction

    function automatic logic [11:0] ref_frame(input logic [7:0] d, input int len, input int pm, input logic fx);
        logic [11:0] v = '0;
        for (int i = 0; i < len; i++) v[1+i] = d[i];
        if (pm != 0) v[1+len] = ref_par(d, len, pm, fx);
        v[len + 1 + (pm != 0 ? 1 : 0)] = 1'b1;
        return v;
    endfunction

    // Drive one frame on rxd; a low stop is shortened so it ends after the sample point.
    task automatic send_frame(input logic [7:0] d, input int len, input int pm,
                              input logic fx, input bit flip, input logic stop_v);
        rxd = 1'b0; clks(32);
        for (int i = 0; i < len; i++) begin rxd = d[i]; clks(32); end
        if (pm != 0) begin rxd = ref_par(d, len, pm, fx) ^ flip; clks(32); end
        rxd = stop_v; clks(stop_v ? 32 : 24);
        rxd = 1'b1; clks(8);
    endtask

    task automatic cap_tx(input int nb, output logic [11:0] bits);
        int t = 0;
        bits = '1;
        while (txd !== 1'b0 && t < 4000) begin clks(1); t++; end
        if (t >= 4000) return;
        clks(16);
        for (int i = 0; i < nb; i++) begin bits[i] = txd; clks(32); end
    endtask

    task automatic wait_rx(input int lim);
        int t = 0;
        while (!rx_ready && t < lim) begin clks(1); t++; end
    endtask

    task automatic t_reset();
        chk(txd === 1'b1, "R1 idle txd", txd, 1);
        chk(tx_ready === 1'b1, "R4 reset tx_ready", tx_ready, 1);
        chk(rx_ready === 1'b0, "R5 reset rx_ready", rx_ready, 0);
        chk(irq_n === 1'b1, "R11 reset irq_n", irq_n, 1);
        irq_mask = 4'b0001; clks(1);
        chk(irq_n === 1'b0, "R11 tx_ready source", irq_n, 0);
        irq_mask = 4'b0010; clks(1);
        chk(irq_n === 1'b1, "R11 rx_ready masked in but clear", irq_n, 1);
        irq_mask = 4'b0;
    endtask

    task automatic t_tx(input logic [7:0] d, input int ls, input int pm, input logic fx);
        logic [11:0] got, exp;
        int nb;
        len_sel = 2'(ls); par_sel = 2'(pm); par_fix = fx; stop_ticks = 6'd16;
        nb = ls + 5 + 2 + (pm != 0 ? 1 : 0);
        exp = ref_frame(d, ls + 5, pm, fx);
        do_write(d);
        chk(tx_ready === 1'b0, "R4 write clears tx_ready", tx_ready, 0);
        cap_tx(nb, got);
        chk((got & 12'((1 << nb) - 1)) == exp, "R1/R2 tx frame", int'(got), int'(exp));
        chk(tx_ready === 1'b1, "R4 tx_ready after hand-over", tx_ready, 1);
        clks(64);
    endtask

    task automatic t_stop(input int req, input int expt);
        int cnt = 0, t = 0;
        len_sel = 2'd3; par_sel = 2'd0; stop_ticks = 6'(req);
        do_write(8'h00);
        while (!tx_ready && t < 100) begin clks(1); t++; end
        do_write(8'h00);
        t = 0; while (txd !== 1'b0 && t < 400) begin clks(1); t++; end
        t = 0; while (txd !== 1'b1 && t < 400) begin clks(1); t++; end
        while (txd === 1'b1 && cnt < 200) begin clks(1); cnt++; end
        chk(cnt >= 2*expt - 1 && cnt <= 2*expt + 1, "R3 stop length clocks", cnt, 2*expt);
        clks(700);
        stop_ticks = 6'd16;
    endtask

    task automatic t_brk_tx();
        brk_send = 1'b1; clks(2);
        chk(txd === 1'b0, "R9 break command holds txd low", txd, 0);
        clks(40);
        chk(txd === 1'b0, "R9 break still low", txd, 0);
        brk_send = 1'b0; clks(2);
        chk(txd === 1'b1, "R9 release restores idle", txd, 1);
    endtask

    task automatic t_rx_basic();
        len_sel = 2'd3; par_sel = 2'd0;
        send_frame(8'h3C, 8, 0, 0, 0, 1);
        chk(rx_ready === 1'b1, "R5 rx_ready set", rx_ready, 1);
        chk(host_rdata == 8'h3C, "R5 rx data", host_rdata, 8'h3C);
        chk(par_err === 1'b0 && frm_err === 1'b0, "R7 clean char no errors", {par_err, frm_err}, 0);
        irq_mask = 4'b0010; clks(1);
        chk(irq_n === 1'b0, "R11 rx_ready interrupt", irq_n, 0);
        do_read(); clks(1);
        chk(rx_ready === 1'b0, "R5 read clears rx_ready", rx_ready, 0);
        chk(irq_n === 1'b1, "R11 irq drops after read", irq_n, 1);
        irq_mask = 4'b0;
    endtask

    task automatic t_rx_par(input int ls, input int pm, input logic fx, input bit flip, input logic [7:0] d);
        logic [7:0] m;
        m = d & 8'((1 << (ls + 5)) - 1);
        len_sel = 2'(ls); par_sel = 2'(pm); par_fix = fx;
        send_frame(m, ls + 5, pm, fx, flip, 1);
        chk(rx_ready === 1'b1 && host_rdata == m, "R2 rx char with parity", host_rdata, m);
        chk(par_err === flip, "R2/R7 parity check result", par_err, flip);
        do_read(); clks(1);
        chk(par_err === 1'b0, "R5 read clears parity error", par_err, 0);
        par_sel = 2'd0; len_sel = 2'd3;
    endtask

    task automatic t_frame_err();
        send_frame(8'h81, 8, 0, 0, 0, 0);
        clks(400);
        chk(frm_err === 1'b1 && host_rdata == 8'h81, "R7 framing error", {frm_err, host_rdata}, 9'h181);
        chk(brk_active === 1'b0, "R8 no break on framing error", brk_active, 0);
        do_read();
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 8, 0, 0, 0, 1);
        send_frame(8'h22, 8, 0, 0, 0, 1);
        chk(overrun === 1'b1, "R7 overrun set", overrun, 1);
        chk(host_rdata == 8'h11, "R7 old char kept", host_rdata, 8'h11);
        irq_mask = 4'b1000; clks(1);
        chk(irq_n === 1'b0, "R11 error interrupt", irq_n, 0);
        do_read(); clks(1);
        chk(overrun === 1'b0 && rx_ready === 1'b0, "R5 read clears overrun", {overrun, rx_ready}, 0);
        irq_mask = 4'b0;
    endtask

    task automatic t_false_start();
        rxd = 1'b0; clks(10); rxd = 1'b1; clks(400);
        chk(rx_ready === 1'b0 && frm_err === 1'b0, "R6 glitch ignored", {rx_ready, frm_err}, 0);
        chk(brk_active === 1'b0, "R6 glitch no break", brk_active, 0);
        send_frame(8'h5A, 8, 0, 0, 0, 1);
        chk(rx_ready === 1'b1 && host_rdata == 8'h5A, "R6 receiver recovers", host_rdata, 8'h5A);
        do_read();
    endtask

    task automatic t_break(input bit mid);
        if (mid) begin
            rxd = 1'b0; clks(32); rxd = 1'b1; clks(64);
        end
        rxd = 1'b0; clks(mid ? 700 : 384);
        chk(brk_active === 1'b1 && brk_change === 1'b1, "R8 break start", {brk_active, brk_change}, 3);
        if (mid) begin
            chk(rx_ready === 1'b1 && frm_err === 1'b1 && host_rdata == 8'h03,
                "R8 mid-char break delivers garbled char", host_rdata, 8'h03);
            do_read();
        end else begin
            chk(rx_ready === 1'b0, "R8 break delivers no char", rx_ready, 0);
        end
        irq_mask = 4'b0100; clks(1);
        chk(irq_n === 1'b0, "R11 break interrupt", irq_n, 0);
        pulse_clr(); clks(1);
        chk(brk_change === 1'b0, "R8 clear break change", brk_change, 0);
        rxd = 1'b1; clks(20); rxd = 1'b0; clks(64);
        chk(brk_active === 1'b1, "R8 short high does not end break", brk_active, 1);
        rxd = 1'b1; clks(64);
        chk(brk_active === 1'b0 && brk_change === 1'b1, "R8 break end", {brk_active, brk_change}, 1);
        pulse_clr(); irq_mask = 4'b0;
        send_frame(8'hC6, 8, 0, 0, 0, 1);
        chk(rx_ready === 1'b1 && host_rdata == 8'hC6, "R8 receive after break", host_rdata, 8'hC6);
        do_read();
    endtask

    task automatic t_local();
        int hi_bad = 0;
        chan_sel = 2'd2; clks(2);
        do_write(8'h96);
        for (int t = 0; t < 600 && !rx_ready; t++) begin
            if (txd !== 1'b1) hi_bad++;
            clks(1);
        end
        chk(rx_ready === 1'b1 && host_rdata == 8'h96, "R10 local loopback char", host_rdata, 8'h96);
        chk(hi_bad == 0, "R10 local loopback txd idle", hi_bad, 0);
        do_read(); clks(200);
        chan_sel = 2'd0; clks(4);
    endtask

    task automatic t_mirror(input int mode, input logic [7:0] d);
        int bad = 0;
        chan_sel = 2'(mode); clks(4);
        fork
            send_frame(d, 8, 0, 0, 0, 1);
            for (int i = 0; i < 10; i++) begin
                clks(i == 0 ? 16 : 32);
                if (txd !== rxd) bad++;
            end
        join
        chk(bad == 0, "R10 txd follows rxd", bad, 0);
        if (mode == 1) begin
            chk(rx_ready === 1'b1 && host_rdata == d, "R10 echo still receives", host_rdata, d);
            do_read();
        end else begin
            chk(rx_ready === 1'b0, "R10 remote loopback no rx_ready", rx_ready, 0);
        end
        chan_sel = 2'd0; clks(4);
    endtask

    initial begin
        clks(4); rst_n = 1'b1; clks(4);
        t_reset();
        t_tx(8'hA5, 3, 0, 1'b0);
        t_tx(8'h16, 0, 2, 1'b0);
        t_tx(8'h00, 2, 3, 1'b1);
        t_tx(8'h2B, 1, 1, 1'b0);
        t_stop(9, 9);
        t_stop(32, 32);
        t_stop(3, 9);
        t_stop(40, 32);
        t_stop(20, 20);
        t_brk_tx();
        t_rx_basic();
        t_rx_par(1, 1, 1'b0, 1'b0, 8'h2B);
        t_rx_par(2, 2, 1'b0, 1'b1, 8'h55);
        t_rx_par(3, 3, 1'b0, 1'b1, 8'hF0);
        t_rx_par(3, 3, 1'b1, 1'b0, 8'h0F);
        t_frame_err();
        t_overrun();
        t_false_start();
        t_break(1'b0);
        t_break(1'b1);
        t_local();
        t_mirror(1, 8'hC3);
        t_mirror(3, 8'h69);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule